// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block receives a demodulated infrared signal and records the length of every mark and every gap as an 8-bit count of sample ticks. The sample tick is derived from the core clock in two steps. A fixed prescaler comes first. A programmable divisor, set over the register bus, follows it. The counts are stored in order into a bank of 32-bit capture words, four counts to a word. Marks and gaps alternate, and the first count is always a mark.

A message ends when a gap runs long enough to saturate its counter. A message also ends when every capture slot is full. Either event sets a status bit, and that bit can drive an interrupt line. Software reads the capture words, clears the status and writes a restart to arm the receiver for the next message.

Top module: `ir_capture_ctrl`

## Requirements
- R1: Capture runs only while both enable bits of the control word at 0x0C are 1 (bit 0 receiver on, bit 13 width measurement on). Both bits read back. If either bit is 0, the engine returns to idle, no counts are stored, and the stored counts are kept.
- R2: The divisor field sits at 0x10 bits 20:8 and resets to 0xC00. One sample tick lasts 4×D core clocks, where D is the divisor. A value of 0 acts as 1.
- R3: `ir_i` passes through two synchronising flops. A level that lasts N core clocks between two edges stores floor((N−1)/(4×D)).
- R4: Slot k is held in the capture word at 0x88 + 4×(k div 4), in bits 8×(k mod 4)+7 down to 8×(k mod 4). Slots fill in order from 0. Words at 0x88..0xC8 hold 68 slots.
- R5: A high level on `ir_i` is a mark. From idle, capture starts only on a rising edge, so a low input in idle stores nothing. Even slots hold marks and odd slots hold gaps.
- R6: A mark count stops at 0xFF and the message goes on. A gap count that reaches 0xFF stores 0xFF, ends the message and sets status.
- R7: Status is set when slot 67 is written. Nothing more is stored until a restart.
- R8: Writing 1 to bit 0 of 0x20 clears every capture word, resets the slot index to 0 and returns the engine to idle.
- R9: Status reads at 0xD0 bit 0, and writing 1 there clears it. If a set and a clear occur in the same cycle, the set wins. The interrupt enable is 0xCC bit 0, and `irq_o` = status AND enable.
- R10: Reads of unmapped offsets return 0. Writes to unmapped offsets and to the capture words change nothing.
- R11: After reset, 0x0C, 0xCC and 0xD0 read 0, 0x10 reads 0x000C0000, all capture words read 0, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address of register access |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| ir_i | input | 1 | Demodulated infrared level, high = mark |
| irq_o | output | 1 | Interrupt request |

## Verification
A table of mixed mark and gap lengths, including a zero-length mark and lengths from 1 to 12 ticks, shows whether counts land in the right lane and word. It also shows that marks and gaps keep their alternation. A long trailing gap separates the end-of-message path from an ordinary gap store. A very long mark confirms that mark saturation does not end the message. A full 68-slot message checks the fill limit, and the extra activity after it must store nothing. A run with divisor 0 and a run with only one enable bit set check the tick derivation and the gating.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_DIV  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RSTR = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CAP  = 8'h88;
  localparam logic [ADDR_W-1:0] OFF_IEN  = 8'hCC;
  localparam logic [ADDR_W-1:0] OFF_ICLR = 8'hD0;
  localparam int BIT_RX_EN = 0;
  localparam int BIT_PW_EN = 13;
  localparam int DIV_LSB   = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MARK  = 2'd1,
    ST_GAP   = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;
endpackage

// File: rtl/ir_cap_sync.sv
module ir_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ir_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], ir_i};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;

  // a rise means the input was high STAGES cycles earlier
  AST_RISE_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> $past(ir_i, STAGES)) else $error("rise without input"); // R3
endmodule

// File: rtl/ir_cap_ticker.sv
module ir_cap_ticker #(
  parameter int PRE_DIV = 4,
  parameter int DIV_W   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] smp_q;
  logic [DIV_W-1:0] div_eff;
  logic             pre_wrap;

  assign div_eff  = (div_i == '0) ? DIV_W'(1) : div_i;
  assign pre_wrap = (pre_q == PRE_W'(PRE_DIV - 1));
  assign tick_o   = pre_wrap && (smp_q >= div_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      smp_q <= '0;
    end else if (clr_i) begin
      pre_q <= '0;
      smp_q <= '0;
    end else if (pre_wrap) begin
      pre_q <= '0;
      smp_q <= tick_o ? '0 : smp_q + DIV_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  if (PRE_DIV > 1) begin : g_chk
    AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |=> !tick_o) else $error("back-to-back ticks"); // R2
  end
endmodule

// File: rtl/ir_cap_engine.sv
module ir_cap_engine
  import ir_cap_pkg::*;
#(
  parameter int NUM_SLOTS = 68,
  parameter int CNT_W     = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              tick_i,
  output logic              clr_phase_o,
  output logic              wr_en_o,
  output logic [SLOT_W-1:0] wr_slot_o,
  output logic [CNT_W-1:0]  wr_data_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(NUM_SLOTS - 1);

  cap_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              last;

  assign last      = (slot_q == SLOT_END);
  assign wr_slot_o = slot_q;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    slot_d      = slot_q;
    wr_en_o     = 1'b0;
    wr_data_o   = cnt_q;
    done_o      = 1'b0;
    clr_phase_o = 1'b0;
    if (restart_i || !run_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      slot_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rise_i) begin
            state_d     = ST_MARK;
            cnt_d       = '0;
            clr_phase_o = 1'b1;
          end
        end
        ST_MARK: begin
          if (fall_i) begin
            wr_en_o     = 1'b1;
            slot_d      = slot_q + SLOT_W'(1);
            cnt_d       = '0;
            clr_phase_o = 1'b1;
            if (last) begin
              state_d = ST_DONE;
              done_o  = 1'b1;
            end else begin
              state_d = ST_GAP;
            end
          end else if (tick_i && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (rise_i) begin
            wr_en_o     = 1'b1;
            slot_d      = slot_q + SLOT_W'(1);
            cnt_d       = '0;
            clr_phase_o = 1'b1;
            if (last) begin
              state_d = ST_DONE;
              done_o  = 1'b1;
            end else begin
              state_d = ST_MARK;
            end
          end else if (tick_i) begin
            if (cnt_q == CNT_MAX - CNT_W'(1)) begin
              // saturated gap closes the message
              wr_en_o   = 1'b1;
              wr_data_o = CNT_MAX;
              slot_d    = slot_q + SLOT_W'(1);
              state_d   = ST_DONE;
              done_o    = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slot_q  <= slot_d;
    end
  end

  AST_EVEN_IS_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_slot_o[0]) |-> state_q == ST_MARK) else $error("even slot not mark"); // R5
  AST_ODD_IS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && wr_slot_o[0]) |-> state_q == ST_GAP) else $error("odd slot not gap"); // R5
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DONE |-> !wr_en_o) else $error("store after done"); // R7
  AST_SLOT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= SLOT_W'(NUM_SLOTS)) else $error("slot overflow"); // R7
  AST_SAT_GAP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_GAP && wr_en_o && wr_data_o == CNT_MAX) |=> state_q == ST_DONE)
    else $error("saturated gap did not end"); // R6
  AST_GATED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> state_q == ST_IDLE) else $error("runs while disabled"); // R1
endmodule

// File: rtl/ir_cap_bank.sv
module ir_cap_bank #(
  parameter int NUM_WORDS = 17,
  parameter int CNT_W     = 8,
  parameter int SLOT_W    = 7,
  localparam int LANES    = 32 / CNT_W,
  localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WORD_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic [WORD_W-1:0] rd_idx_i,
  output logic [31:0]       rd_word_o
);
  logic [31:0]       word_q [NUM_WORDS];
  logic [WORD_W-1:0] wr_word;
  logic [LANE_W-1:0] wr_lane;

  assign wr_word = WORD_W'(wr_slot_i / SLOT_W'(LANES));
  assign wr_lane = LANE_W'(wr_slot_i % SLOT_W'(LANES));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          word_q[w][l*CNT_W +: CNT_W] <= '0;
        end else if (clr_i) begin
          word_q[w][l*CNT_W +: CNT_W] <= '0;
        end else if (wr_en_i && wr_word == WORD_W'(w) && wr_lane == LANE_W'(l)) begin
          word_q[w][l*CNT_W +: CNT_W] <= wr_data_i;
        end
      end
    end
  end

  always_comb begin
    rd_word_o = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rd_idx_i == WORD_W'(w)) rd_word_o = word_q[w];
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (word_q[0] == '0 && word_q[NUM_WORDS-1] == '0)) else $error("clear failed"); // R8
endmodule

// File: rtl/ir_capture_ctrl.sv
module ir_capture_ctrl
  import ir_cap_pkg::*;
#(
  parameter int NUM_WORDS = 17,
  parameter int CNT_W     = 8,
  parameter int PRE_DIV   = 4,
  parameter int DIV_W     = 13,
  parameter logic [DIV_W-1:0] DIV_RST = 13'hC00,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              ir_i,
  output logic              irq_o
);
  localparam int LANES     = 32 / CNT_W;
  localparam int NUM_SLOTS = NUM_WORDS * LANES;
  localparam int SLOT_W    = $clog2(NUM_SLOTS + 1);
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int CAP_END   = int'(OFF_CAP) + 4 * NUM_WORDS;

  logic             rx_en_q, pw_en_q, ien_q, status_q;
  logic [DIV_W-1:0] div_q;
  logic             run, restart, clr_req;
  logic             lvl, rise, fall, tick, clr_phase;
  logic             wr_en, done;
  logic [SLOT_W-1:0] wr_slot;
  logic [CNT_W-1:0]  wr_data;
  logic              aligned, cap_hit;
  logic [WORD_W-1:0] cap_idx;
  logic [31:0]       cap_word;
  logic              unused_lvl;

  assign unused_lvl = lvl;
  assign run     = rx_en_q & pw_en_q;
  assign aligned = (addr_i[1:0] == 2'b00);
  assign restart = we_i && aligned && addr_i == OFF_RSTR && wdata_i[0];
  assign clr_req = we_i && aligned && addr_i == OFF_ICLR && wdata_i[0];
  assign cap_hit = aligned && int'(addr_i) >= int'(OFF_CAP) && int'(addr_i) < CAP_END;
  assign cap_idx = WORD_W'((addr_i - OFF_CAP) >> 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_en_q <= 1'b0;
      pw_en_q <= 1'b0;
      ien_q   <= 1'b0;
      div_q   <= DIV_RST;
    end else if (we_i && aligned) begin
      if (addr_i == OFF_CTRL) begin
        rx_en_q <= wdata_i[BIT_RX_EN];
        pw_en_q <= wdata_i[BIT_PW_EN];
      end
      if (addr_i == OFF_DIV) div_q <= wdata_i[DIV_LSB +: DIV_W];
      if (addr_i == OFF_IEN) ien_q <= wdata_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      status_q <= 1'b0;
    else if (done)    status_q <= 1'b1;
    else if (clr_req) status_q <= 1'b0;
  end

  assign irq_o = status_q & ien_q;

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (addr_i == OFF_CTRL) begin
        rdata_o[BIT_RX_EN] = rx_en_q;
        rdata_o[BIT_PW_EN] = pw_en_q;
      end else if (addr_i == OFF_DIV) begin
        rdata_o[DIV_LSB +: DIV_W] = div_q;
      end else if (addr_i == OFF_IEN) begin
        rdata_o[0] = ien_q;
      end else if (addr_i == OFF_ICLR) begin
        rdata_o[0] = status_q;
      end else if (cap_hit) begin
        rdata_o = cap_word;
      end
    end
  end

  ir_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ir_i   (ir_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  ir_cap_ticker #(.PRE_DIV(PRE_DIV), .DIV_W(DIV_W)) u_ticker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_phase),
    .div_i  (div_q),
    .tick_o (tick)
  );

  ir_cap_engine #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .restart_i   (restart),
    .rise_i      (rise),
    .fall_i      (fall),
    .tick_i      (tick),
    .clr_phase_o (clr_phase),
    .wr_en_o     (wr_en),
    .wr_slot_o   (wr_slot),
    .wr_data_o   (wr_data),
    .done_o      (done)
  );

  ir_cap_bank #(.NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (restart),
    .wr_en_i   (wr_en),
    .wr_slot_i (wr_slot),
    .wr_data_i (wr_data),
    .rd_idx_i  (cap_idx),
    .rd_word_o (cap_word)
  );

  AST_STATUS_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_q) |-> $past(done)) else $error("status without end"); // R9
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> status_q) else $error("status not set"); // R9
  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req && !done) |=> !irq_o) else $error("irq after clear"); // R9
endmodule

// File: tb/sim_ir_capture_ctrl.sv
module sim_ir_capture_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ir = 1'b0;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  localparam int unsigned VEC [9] = '{4, 2, 9, 1, 0, 3, 12, 6, 1};
  localparam int T2 = 8;   // divisor 2 -> 8 clocks per tick

  always #2 clk = ~clk;

  ir_capture_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .ir_i(ir), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic expect_reg(string req, logic [7:0] a, logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    check(req, v, e);
  endtask

  task automatic hold(logic v, int n);
    ir = v;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-reqs act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0]  exp_b [68];
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    expect_reg("R11 ctrl", 8'h0C, 32'h0);
    expect_reg("R11 div", 8'h10, 32'h000C0000);
    expect_reg("R11 ien", 8'hCC, 32'h0);
    expect_reg("R11 status", 8'hD0, 32'h0);
    expect_reg("R11 cap0", 8'h88, 32'h0);
    check("R11 irq", {31'b0, irq}, 32'h0);

    // R1 only one enable bit: nothing captured
    wr(8'h10, 32'd2 << 8);
    wr(8'h0C, 32'h1);
    expect_reg("R1 readback", 8'h0C, 32'h1);
    hold(0, 10); hold(1, 3*T2+4); hold(0, 2*T2+4); hold(1, 20); hold(0, 20);
    expect_reg("R1 gated", 8'h88, 32'h0);
    wr(8'h0C, 32'h2001);
    expect_reg("R1 both", 8'h0C, 32'h2001);
    wr(8'h20, 32'h1);

    // R5 low input in idle stores nothing
    hold(0, 40);
    expect_reg("R5 idle low", 8'h88, 32'h0);

    // table walk: R3 R4 R5, then saturated gap R6
    for (int i = 0; i < 9; i++) hold(i % 2 == 0, int'(VEC[i]) * T2 + 4);
    hold(0, 255*T2 + 40);
    for (int w = 0; w < 3; w++) begin
      logic [31:0] e;
      e = '0;
      for (int l = 0; l < 4; l++) begin
        int k;
        k = w*4 + l;
        if (k < 9) e[l*8 +: 8] = 8'(VEC[k]);
        else if (k == 9) e[l*8 +: 8] = 8'hFF;
      end
      rd(8'(8'h88 + 4*w), v);
      check("R4 table word", v, e);
    end
    expect_reg("R6 end status", 8'hD0, 32'h1);

    // R9 interrupt gating and clear
    check("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(8'hCC, 32'h1);
    @(negedge clk);
    check("R9 irq on", {31'b0, irq}, 32'h1);
    wr(8'hD0, 32'h1);
    @(negedge clk);
    check("R9 irq cleared", {31'b0, irq}, 32'h0);
    expect_reg("R9 status cleared", 8'hD0, 32'h0);

    // R10 unmapped and read-only capture
    wr(8'h04, 32'hFFFF_FFFF);
    expect_reg("R10 unmapped read", 8'h04, 32'h0);
    wr(8'h88, 32'h1234_5678);
    expect_reg("R10 cap read-only", 8'h88, 32'h01090204);
    expect_reg("R10 div untouched", 8'h10, 32'h00000200);

    // R6 mark saturates, message continues
    wr(8'h20, 32'h1);
    hold(0, 10); hold(1, 300*T2); hold(0, 2*T2+4); hold(1, 20);
    expect_reg("R6 mark sat", 8'h88, 32'h000002FF);
    expect_reg("R6 no end", 8'hD0, 32'h0);

    // R2 divisor 0 acts as 1 (4 clocks per tick)
    wr(8'h10, 32'h0);
    wr(8'h20, 32'h1);
    hold(0, 10); hold(1, 3*4+2); hold(0, 5*4+2); hold(1, 2*4+2); hold(0, 10);
    expect_reg("R2 div zero", 8'h88, 32'h00020503);

    // R7 fill all 68 slots
    wr(8'h10, 32'd2 << 8);
    wr(8'h20, 32'h1);
    hold(0, 10);
    for (int k = 0; k < 68; k++) begin
      exp_b[k] = 8'((k*7 + 3) % 11);
      hold(k % 2 == 0, int'(exp_b[k]) * T2 + 4);
    end
    hold(1, 20); hold(0, 20);
    expect_reg("R7 full status", 8'hD0, 32'h1);
    for (int w = 0; w < 17; w++) begin
      rd(8'(8'h88 + 4*w), v);
      check("R7 full word", v, {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]});
    end
    hold(1, 30); hold(0, 30); hold(1, 30);
    expect_reg("R7 ignored w0", 8'h88, {exp_b[3], exp_b[2], exp_b[1], exp_b[0]});
    expect_reg("R7 beyond bank", 8'hCC + 8'h4, 32'h1);

    // R8 restart clears and rearms
    hold(0, 10);
    wr(8'h20, 32'h1);
    expect_reg("R8 cleared w0", 8'h88, 32'h0);
    expect_reg("R8 cleared w16", 8'hC8, 32'h0);
    hold(1, 1*T2+4); hold(0, 20);
    expect_reg("R8 rearmed", 8'h88, 32'h00000001);

    // R1 disable mid-message keeps data
    wr(8'h0C, 32'h2000);
    hold(1, 20); hold(0, 20);
    expect_reg("R1 data kept", 8'h88, 32'h00000001);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule